// File: doc/BRIEF.md
# Block and Sync Regenerator Driven by Valid

This block rebuilds the framing sideband of a sample stream after a processing stage that kept only data and valid. It counts valid samples into blocks of fixed length and flags the first and last sample of each block. It also flags the first block of every sync interval and numbers the blocks with a local block sequence number (BSN). A global BSN, captured whenever the upstream sync strobe arrives, is carried across and presented on the output either at each sync or at every block start. This approach suits paths whose latency spans many blocks or a whole sync interval, because no sideband needs to be delayed alongside the data.

The sync interval is tied to a one-second grid. When the samples per second are not a whole multiple of the block length, the average number of blocks per second is fractional. Interval lengths therefore alternate between N and N+1 blocks, with N = SPS / BLK_LEN. An accumulator adds the remainder SPS mod BLK_LEN once per interval. The next interval gets one extra block whenever the accumulator reaches BLK_LEN, and BLK_LEN is then subtracted. Numbering intervals from k = 0 after reset, interval k holds N + floor((k+1)*R/L) - floor(k*R/L) blocks, where R is the remainder and L the block length. With 200 MHz sampling and 1024-sample blocks this yields the pattern 195312, 195313, and so on.

All outputs are registered and appear one clock after the input sample that causes them.

Top module: `valid_block_framer`

## Requirements
- R1: While reset is asserted, and until the first valid sample after its release, out_valid, out_sop, out_eop, out_sync, out_bsn and out_gbsn are all zero.
- R2: out_valid equals in_valid delayed by exactly one clock.
- R3: out_sop is high, one clock after a valid sample, exactly when that sample is the first of a block. Counting restarts after every block, and cycles with in_valid low do not advance the count.
- R4: out_eop is high exactly on the BLK_LEN-th valid sample of a block, and the next valid sample starts a new block.
- R5: out_sync is high only together with out_sop, on the first block of each interval. Interval k (k = 0 after reset) contains SPS/BLK_LEN + floor((k+1)*R/BLK_LEN) - floor(k*R/BLK_LEN) blocks, where R = SPS mod BLK_LEN.
- R6: At each out_sop, out_bsn shows the block index since reset: 0 for the first block, then +1 per block, wrapping modulo 2^BSN_W with no gap. Between block starts it holds its value.
- R7: When GBSN_ALL_SOP is 0, out_gbsn is loaded at each out_sync with the in_gbsn value most recently captured by in_sync. An in_sync in the same cycle as the sync sample supplies its own value.
- R8: When GBSN_ALL_SOP is 1, out_gbsn is loaded the same way at every out_sop. In either mode, out_gbsn does not change on any other cycle, whatever in_sync and in_gbsn do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe of the incoming stream |
| in_sync | input | 1 | Capture strobe for in_gbsn |
| in_gbsn | input | GBSN_W | Global BSN offered with in_sync |
| out_valid | output | 1 | Delayed sample strobe |
| out_sop | output | 1 | First sample of a block |
| out_eop | output | 1 | Last sample of a block |
| out_sync | output | 1 | First sample of the first block of an interval |
| out_bsn | output | BSN_W | Local block sequence number |
| out_gbsn | output | GBSN_W | Carried global BSN |

## Verification
The bench builds two instances. The first uses BLK_LEN 4, SPS 10 and BSN_W 4. This gives a half-block remainder, so intervals alternate between 2 and 3 blocks, and the local BSN wraps after 16 blocks. Both effects fall within a few hundred cycles. The second uses BLK_LEN 8, SPS 27 and GBSN_ALL_SOP 1. Its remainder of 3/8 gives an irregular carry pattern with a period of eight intervals, and it exercises the every-block global BSN mode. Both instances see the same bursty and continuous valid patterns, including a reset in the middle of a run.

// File: rtl/valid_block_framer.sv
module valid_block_framer #(
  parameter int BLK_LEN      = 1024,
  parameter int SPS          = 200000000,
  parameter int ACC_W        = $clog2(BLK_LEN) + 1,
  parameter int BSN_W        = 48,
  parameter int GBSN_W       = 64,
  parameter bit GBSN_ALL_SOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic [GBSN_W-1:0] in_gbsn,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_sync,
  output logic [BSN_W-1:0]  out_bsn,
  output logic [GBSN_W-1:0] out_gbsn
);

  localparam int BASE  = SPS / BLK_LEN;
  localparam int REM   = SPS % BLK_LEN;
  localparam int SMP_W = $clog2(BLK_LEN);
  localparam int CNT_W = $clog2(BASE + 1) + 1;

  logic [SMP_W-1:0]  smp_cnt;
  logic [CNT_W-1:0]  blk_cnt;
  logic [ACC_W-1:0]  acc;
  logic              extra;
  logic [BSN_W-1:0]  bsn_cnt;
  logic [GBSN_W-1:0] gbsn_hold;

  logic              first, last, ival_head, ival_last, carry;
  logic [ACC_W:0]    acc_sum;
  logic [GBSN_W-1:0] gbsn_now;

  assign first     = in_valid && (smp_cnt == '0);
  assign last      = in_valid && (smp_cnt == SMP_W'(BLK_LEN - 1));
  assign ival_head = (blk_cnt == '0);
  assign ival_last = (blk_cnt == CNT_W'(BASE - 1) + CNT_W'(extra));
  assign acc_sum   = {1'b0, acc} + (ACC_W+1)'(REM);
  assign carry     = (acc_sum >= (ACC_W+1)'(BLK_LEN));
  assign gbsn_now  = in_sync ? in_gbsn : gbsn_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_cnt   <= '0;
      blk_cnt   <= '0;
      acc       <= ACC_W'(REM);
      extra     <= 1'b0;
      bsn_cnt   <= '0;
      gbsn_hold <= '0;
    end else begin
      if (last) begin
        smp_cnt <= '0;
        if (ival_last) begin
          blk_cnt <= '0;
          extra   <= carry;
          acc     <= carry ? ACC_W'(acc_sum - (ACC_W+1)'(BLK_LEN)) : ACC_W'(acc_sum);
        end else begin
          blk_cnt <= blk_cnt + 1'b1;
        end
      end else if (in_valid) begin
        smp_cnt <= smp_cnt + 1'b1;
      end
      if (first)   bsn_cnt   <= bsn_cnt + 1'b1;
      if (in_sync) gbsn_hold <= in_gbsn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_sync  <= 1'b0;
      out_bsn   <= '0;
      out_gbsn  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sop   <= first;
      out_eop   <= last;
      out_sync  <= first && ival_head;
      if (first) out_bsn <= bsn_cnt;
      if (first && (GBSN_ALL_SOP || ival_head)) out_gbsn <= gbsn_now;
    end
  end

  a_r3_sop_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  a_r4_eop_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);
  a_r4_smp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    smp_cnt <= SMP_W'(BLK_LEN - 1));
  a_r4_sop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eop && in_valid) |=> out_sop);
  a_r5_sync_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_sop);
  a_r5_blk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cnt <= CNT_W'(BASE));
  a_r6_bsn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_sop |-> $stable(out_bsn));
  a_r8_gbsn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(GBSN_ALL_SOP ? out_sop : out_sync) |-> $stable(out_gbsn));

endmodule

// File: tb/tb_valid_block_framer.sv
module tb_valid_block_framer;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        in_valid;
  logic        in_sync;
  logic [15:0] in_gbsn;

  logic        a_val, a_sop, a_eop, a_sync;
  logic [3:0]  a_bsn;
  logic [15:0] a_gbsn;
  logic        b_val, b_sop, b_eop, b_sync;
  logic [7:0]  b_bsn;
  logic [15:0] b_gbsn;

  valid_block_framer #(.BLK_LEN(4), .SPS(10), .BSN_W(4), .GBSN_W(16), .GBSN_ALL_SOP(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync), .in_gbsn(in_gbsn),
    .out_valid(a_val), .out_sop(a_sop), .out_eop(a_eop), .out_sync(a_sync),
    .out_bsn(a_bsn), .out_gbsn(a_gbsn));

  valid_block_framer #(.BLK_LEN(8), .SPS(27), .BSN_W(8), .GBSN_W(16), .GBSN_ALL_SOP(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync), .in_gbsn(in_gbsn),
    .out_valid(b_val), .out_sop(b_sop), .out_eop(b_eop), .out_sync(b_sync),
    .out_bsn(b_bsn), .out_gbsn(b_gbsn));

  int n_run = 0;
  int n_fail = 0;

  int     P_BLK [2] = '{4, 8};
  int     P_SPS [2] = '{10, 27};
  longint P_MOD [2] = '{16, 256};
  bit     P_ALL [2] = '{1'b0, 1'b1};

  int     m_smp [2];
  int     m_blk [2];
  longint m_k   [2];
  longint m_bsn [2];
  longint m_hold[2];
  bit     e_val [2], e_sop [2], e_eop [2], e_sync [2];
  longint e_bsn [2], e_gbsn [2];

  // Stimulus table: [16] pulses in_sync on the first cycle of the entry, [15:0] valid per cycle (LSB first)
  localparam int NPAT = 8;
  localparam logic [16:0] PAT [NPAT] = '{
    17'h1FFFF, 17'h0AAAA, 17'h0F0F0, 17'h1FFFF,
    17'h06DB6, 17'h0FFFF, 17'h18421, 17'h0FFFF
  };

  function automatic int ival_len(input int u, input longint k);
    longint r, l;
    r = P_SPS[u] % P_BLK[u];
    l = P_BLK[u];
    return P_SPS[u] / P_BLK[u] + int'(((k + 1) * r) / l - (k * r) / l);
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_smp[u] = 0; m_blk[u] = 0; m_k[u] = 0; m_bsn[u] = 0; m_hold[u] = 0;
      e_val[u] = 0; e_sop[u] = 0; e_eop[u] = 0; e_sync[u] = 0; e_bsn[u] = 0; e_gbsn[u] = 0;
    end
  endtask

  task automatic model_step(input bit v, input bit s, input longint g);
    for (int u = 0; u < 2; u++) begin
      longint gnow;
      gnow      = s ? g : m_hold[u];
      if (s) m_hold[u] = g;
      e_val[u]  = v;
      e_sop[u]  = v && (m_smp[u] == 0);
      e_eop[u]  = v && (m_smp[u] == P_BLK[u] - 1);
      e_sync[u] = e_sop[u] && (m_blk[u] == 0);
      if (e_sop[u]) begin
        e_bsn[u] = m_bsn[u];
        m_bsn[u] = (m_bsn[u] + 1) % P_MOD[u];
        if (P_ALL[u] || m_blk[u] == 0) e_gbsn[u] = gnow;
      end
      if (v) begin
        if (e_eop[u]) begin
          m_smp[u] = 0;
          if (m_blk[u] == ival_len(u, m_k[u]) - 1) begin
            m_blk[u] = 0;
            m_k[u]++;
          end else begin
            m_blk[u]++;
          end
        end else begin
          m_smp[u]++;
        end
      end
    end
  endtask

  task automatic chk(input string tag, input int u, input longint got, input longint exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s unit%0d got %0d expected %0d at %0t", tag, u, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 valid", 0, a_val,  e_val[0]);   chk("R2 valid", 1, b_val,  e_val[1]);
    chk("R3 sop",   0, a_sop,  e_sop[0]);   chk("R3 sop",   1, b_sop,  e_sop[1]);
    chk("R4 eop",   0, a_eop,  e_eop[0]);   chk("R4 eop",   1, b_eop,  e_eop[1]);
    chk("R5 sync",  0, a_sync, e_sync[0]);  chk("R5 sync",  1, b_sync, e_sync[1]);
    chk("R6 bsn",   0, a_bsn,  e_bsn[0]);   chk("R6 bsn",   1, b_bsn,  e_bsn[1]);
    chk("R7 gbsn",  0, a_gbsn, e_gbsn[0]);  chk("R8 gbsn",  1, b_gbsn, e_gbsn[1]);
  endtask

  task automatic cyc(input bit v, input bit s, input logic [15:0] g);
    in_valid = v; in_sync = s; in_gbsn = g;
    model_step(v, s, longint'(g));
    @(negedge clk);
    check_all();
  endtask

  task automatic check_r1();
    chk("R1 reset valid", 0, a_val, 0);  chk("R1 reset sop", 1, b_sop, 0);
    chk("R1 reset sync", 0, a_sync, 0);  chk("R1 reset eop", 1, b_eop, 0);
    chk("R1 reset bsn", 0, a_bsn, 0);    chk("R1 reset gbsn", 1, b_gbsn, 0);
  endtask

  initial begin
    #(5 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sync = 1'b0; in_gbsn = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check_r1();
    rst_n = 1'b1;
    @(negedge clk);
    check_r1();

    for (int i = 0; i < NPAT; i++)
      for (int b = 0; b < 16; b++)
        cyc(PAT[i][b], PAT[i][16] && b == 0, 16'(100 + i));

    // R5/R6: continuous run over many intervals with wrap of the 4-bit BSN
    for (int i = 0; i < 600; i++)
      cyc(1'b1, (i % 37) == 5, 16'(500 + i));

    // R3: sparse valid with gaps; in_sync toggling on idle cycles must not disturb out_gbsn (R8)
    for (int i = 0; i < 300; i++)
      cyc((i % 3) != 1, (i % 3) == 1, 16'(2000 + i));

    // R7: in_sync in the same cycle as the sample that starts an interval
    for (int i = 0; i < 200; i++)
      cyc(1'b1, 1'b1, 16'(3000 + i));

    // R1: reset in the middle of a run, then restart from block 0
    in_valid = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    check_r1();
    rst_n = 1'b0; in_valid = 1'b0;
    model_reset();
    @(negedge clk);
    check_r1();
    rst_n = 1'b1;
    for (int i = 0; i < 120; i++)
      cyc(1'b1, 1'b0, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule